// File: doc/BRIEF.md
# Raster Projection-Line Membership Tester

This block serves one fixed projection angle. Pixels of a frame arrive one per clock in raster order, x stepping fastest. For each pixel the block reports whether it falls inside the one-pixel-wide strip that passes through the image centre, perpendicular to the angle direction. Downstream per-angle accumulators use that flag to decide whether to take the pixel into their sums.

The signed offset of a pixel along the angle direction is an affine function of its coordinates. In raster order it therefore moves by only two amounts: one step between neighbours on a row, and another step from the last pixel of a row to the first pixel of the next. The block keeps that offset in a single signed fixed-point accumulator with 16 fractional bits, and needs no multiplier. The three per-angle constants come in as inputs: the offset of pixel (0,0), the in-row step and the row-wrap step. The pixel is on the line when its offset lies within plus or minus one half, with both bounds included.

Top module: `lineMemberTest`

## Requirements
- R1: After reset `onLine` is low and the accumulator holds zero. A pixel presented without a preceding frame start is therefore judged at offset 0.
- R2: `frameStart` loads `initOffset` as the offset of the first pixel of the frame. If `pixValid` is high in the same cycle, that pixel is judged at `initOffset`.
- R3: A valid pixel with `lineEnd` low makes the next pixel's offset equal to the current offset plus `pixelStep`.
- R4: A valid pixel with `lineEnd` high marks the last pixel of its row. The next pixel's offset is then the current offset plus `lineStep`.
- R5: A pixel counts as on the line exactly when its offset v, read as two's complement with 16 fractional bits, satisfies -32768 <= v <= 32768. Both bounds are inclusive, and one LSB beyond either bound is off.
- R6: `onLine` is registered. It gives the verdict for the pixel presented with `pixValid` one clock earlier, and it is low in any cycle after a clock with `pixValid` low.
- R7: In cycles with `pixValid` and `frameStart` both low, the offset is held, and `lineEnd` has no effect.
- R8: A `frameStart` in the middle of a frame discards the running offset and restarts from `initOffset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | First pixel of a frame follows, or is presented in this cycle |
| pixValid | input | 1 | A pixel is presented in this cycle |
| lineEnd | input | 1 | The presented pixel is the last of its row |
| initOffset | input | 30 | Signed offset of pixel (0,0), 16 fractional bits |
| pixelStep | input | 30 | Signed in-row offset increment |
| lineStep | input | 30 | Signed row-wrap offset increment |
| onLine | output | 1 | Registered membership flag for the previous cycle's pixel |

## Verification
The hardest cases to reach are the offsets lying exactly on a bound or one LSB past it. Reaching them by accumulation would need steps tuned to land there precisely. The stimulus reaches them directly instead: it asserts frame start together with a valid pixel, so that the loaded offset itself is the one judged, and it sweeps that offset across both edges. Stall cycles with a stray end-of-row, and frame restarts in the middle of a row, are placed inside long raster walks. A following valid pixel then shows whether the held offset survived intact.

// File: rtl/lineTestPkg.sv
package lineTestPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // reload accumulator with the frame's initial offset
    logic advance;  // a pixel is judged this cycle, offset steps afterwards
    logic wrap;     // the step taken is the row-wrap step
  } strobeT;
endpackage

// File: rtl/lineTestCtrl.sv
module lineTestCtrl
  import lineTestPkg::*;
(
  input  logic   frameStart,
  input  logic   pixValid,
  input  logic   lineEnd,
  output strobeT strobes
);
  always_comb begin
    strobes.load    = frameStart;
    strobes.advance = pixValid;
    // row wrap only counts when a pixel is actually present (R7)
    strobes.wrap    = pixValid & lineEnd;
  end
endmodule

// File: rtl/lineTestDatapath.sv
module lineTestDatapath
  import lineTestPkg::*;
#(
  parameter int W    = 30,
  parameter int FRAC = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobes,
  input  logic signed [W-1:0] initOffset,
  input  logic signed [W-1:0] pixelStep,
  input  logic signed [W-1:0] lineStep,
  output logic                onLine
);
  localparam logic signed [W:0] HALF_WIDE = {{(W-FRAC+1){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [W-1:0] HALF = HALF_WIDE[W-1:0];

  logic signed [W-1:0] acc, cur, step, nextAcc;
  logic signed [W:0]   upperGap, lowerGap;
  logic                inBand;

  // offset of the pixel presented now
  always_comb cur = strobes.load ? initOffset : acc;

  always_comb step = strobes.wrap ? lineStep : pixelStep;
  always_comb nextAcc = cur + step;

  // the two bound checks as one subtractor and one adder
  always_comb begin
    upperGap = HALF_WIDE - {cur[W-1], cur};
    lowerGap = {cur[W-1], cur} + HALF_WIDE;
    inBand   = !upperGap[W] && !lowerGap[W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      onLine <= 1'b0;
    end else begin
      if (strobes.advance)   acc <= nextAcc;
      else if (strobes.load) acc <= initOffset;
      onLine <= strobes.advance && inBand;
    end
  end

  // R6: no verdict without a pixel
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> !onLine);

  // R7: offset held while idle
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.load) |=> $stable(acc));

  // R2: load without pixel takes the initial offset
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.advance) |=> acc == $past(initOffset));

  // R3: in-row step from a running offset
  assert_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.wrap && !strobes.load) |=>
      acc == $past(acc) + $past(pixelStep));

  // R4: row-wrap step from a running offset
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && strobes.wrap && !strobes.load) |=>
      acc == $past(acc) + $past(lineStep));

  // R5: exact bounds are inside
  assert_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && (cur == HALF || cur == -HALF)) |=> onLine);
endmodule

// File: rtl/lineMemberTest.sv
module lineMemberTest
  import lineTestPkg::*;
#(
  parameter int INT_BITS  = 14,
  parameter int FRAC_BITS = 16,
  localparam int W = INT_BITS + FRAC_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStart,
  input  logic                pixValid,
  input  logic                lineEnd,
  input  logic signed [W-1:0] initOffset,
  input  logic signed [W-1:0] pixelStep,
  input  logic signed [W-1:0] lineStep,
  output logic                onLine
);
  strobeT strobes;

  lineTestCtrl ctrl (
    .frameStart(frameStart),
    .pixValid  (pixValid),
    .lineEnd   (lineEnd),
    .strobes   (strobes)
  );

  lineTestDatapath #(.W(W), .FRAC(FRAC_BITS)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .initOffset(initOffset),
    .pixelStep (pixelStep),
    .lineStep  (lineStep),
    .onLine    (onLine)
  );
endmodule

// File: tb/lineMemberTest_test.sv
`timescale 1ns/1ps
module lineMemberTest_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, pixValid = 1'b0, lineEnd = 1'b0;
  logic signed [29:0] initOffset = '0, pixelStep = '0, lineStep = '0;
  logic onLine;

  int checks = 0;
  int fails = 0;
  longint modelAcc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lineMemberTest uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixValid(pixValid),
    .lineEnd(lineEnd), .initOffset(initOffset), .pixelStep(pixelStep),
    .lineStep(lineStep), .onLine(onLine)
  );

  // stimulus table: {frameStart, pixValid, lineEnd}
  localparam logic [2:0] STIM [0:19] = '{
    3'b100, 3'b010, 3'b010, 3'b001, 3'b010, 3'b011, 3'b010, 3'b010,
    3'b000, 3'b010, 3'b011, 3'b110, 3'b010, 3'b010, 3'b011, 3'b010,
    3'b000, 3'b001, 3'b010, 3'b011
  };

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: onLine actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // drive one cycle, sample onLine after the edge, update reference model
  task automatic drive(input bit fs, input bit pv, input bit le, input string tag);
    longint cur;
    logic exp;
    frameStart = fs; pixValid = pv; lineEnd = le;
    cur = fs ? longint'(initOffset) : modelAcc;
    exp = pv && (cur >= -32768) && (cur <= 32768);
    if (pv) modelAcc = cur + (le ? longint'(lineStep) : longint'(pixelStep));
    else if (fs) modelAcc = cur;
    @(posedge clk); #1;
    check(onLine, exp, tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(onLine, 1'b0, "R1 reset");
    rstN = 1'b1;
    modelAcc = 0;
    // R1: first pixel without frame start is judged at offset 0
    drive(0, 1, 0, "R1 zero offset");

    // table walk: angle with cos=0.6 sin=0.8, 4-pixel rows, centre (1.5,1.5)
    initOffset = -30'sd137626; pixelStep = 30'sd39322; lineStep = -30'sd65537;
    foreach (STIM[i]) begin
      string tag;
      if (STIM[i][2])      tag = "R8/R2 frame start";
      else if (!STIM[i][1]) tag = "R7 stall";
      else if (STIM[i][0]) tag = "R4 row wrap";
      else                 tag = "R3 in-row step";
      drive(STIM[i][2], STIM[i][1], STIM[i][0], tag);
    end

    // R5: exact bounds and one LSB beyond, loaded directly
    pixelStep = '0; lineStep = '0;
    initOffset = 30'sd32768;  drive(1, 1, 0, "R5 upper bound");
    initOffset = 30'sd32769;  drive(1, 1, 0, "R5 above upper");
    initOffset = -30'sd32768; drive(1, 1, 0, "R5 lower bound");
    initOffset = -30'sd32769; drive(1, 1, 0, "R5 below lower");
    initOffset = 30'sd0;      drive(1, 1, 0, "R5 centre");

    // R2: load alone, then the pixel in the next cycle
    initOffset = 30'sd20000; pixelStep = 30'sd20000;
    drive(1, 0, 0, "R2 load only");
    initOffset = 30'sd999999; // must not matter now
    drive(0, 1, 0, "R2 loaded offset used");
    drive(0, 1, 0, "R3 step past bound");

    // longer raster walk with negative steps and stalls
    initOffset = 30'sd120000; pixelStep = -30'sd18000; lineStep = 30'sd40000;
    drive(1, 0, 0, "R2 load");
    for (int y = 0; y < 4; y++) begin
      for (int x = 0; x < 7; x++) begin
        if ((x + y) % 4 == 2) drive(0, 0, 1, "R7 stall with lineEnd");
        drive(0, 1, x == 6, (x == 6) ? "R4 row wrap" : "R3 in-row step");
      end
    end
    drive(0, 0, 0, "R6 idle");

    // R8: restart mid-row
    initOffset = 30'sd0; pixelStep = 30'sd30000; lineStep = 30'sd0;
    drive(1, 1, 0, "R8 start");
    drive(0, 1, 0, "R3 step");
    drive(0, 1, 0, "R3 step off");
    drive(1, 1, 0, "R8 restart");
    drive(0, 1, 0, "R8 after restart");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule